// File: doc/BRIEF.md
# Local Bus Watchdog and Interrupt Status

This block sits beside a host bridge that forwards accesses to a slower local bus. Each time the bridge begins a local access, a watchdog counts local clock periods. If the ready handshake has not been seen within a fixed window of nine periods, the block records that the access was aborted. A second detector watches the local interrupt input and records each fresh assertion. Both records sit in a status register with five other system event bits. All status bits are sticky, and reading the status register clears them.

A mask register holds one enable per status bit. The active-low host interrupt output is a level. It stays low while any status bit is set and also enabled in the mask. The two local bus bits only mean something when the block is in bridge mode. In configuration mode they are held at zero, so they never raise the host interrupt.

Two state machines do the work. The ready watchdog has the states `WD_IDLE` and `WD_COUNT`. Its transitions are: start (idle to count), restart (start again while counting), ready-seen (count to idle), and expire (count to idle, with a timeout pulse on the ninth period). The interrupt detector has the states `IRQ_ARMED` and `IRQ_HELD`. Its transitions are: assert (armed to held, giving one event) and release (held to armed).

Top module: `lbs_monitor`

## Requirements
- R1: After reset, the status and mask registers read 0, `reg_rdata` is 0 and `host_irq_n` is 1.
- R2: A write to address 1 stores mask bits 0–4, 14 and 15. Bits 5–13 always read 0. A read of address 1 returns the mask on `reg_rdata` in the cycle after the read strobe is sampled.
- R3: If an access is started by `acc_start` at clock edge E0 and `lb_ready` is sampled high at any edge E1 through E9, status bit 14 is not set. A ready at E9 counts as on time.
- R4: If `lb_ready` is not sampled high at edges E1 through E9, status bit 14 is set by edge E9. A ready seen after the timeout has no effect.
- R5: An `acc_start` sampled while the watchdog is counting restarts the nine-period window from that edge.
- R6: Status bit 15 is set when `lb_irq` is sampled high after being low, or after being low since reset. While `lb_irq` stays high, it is not set again after a clear.
- R7: A read of address 0 returns the status register as it was before that edge, and clears every status bit.
- R8: A set event sampled at the same edge as a status read wins, so that bit stays set after the read.
- R9: When `bridge_mode` is 0 (configuration mode), status bits 14 and 15 are held at 0. They neither set nor drive `host_irq_n`.
- R10: `host_irq_n` is 0 exactly while some status bit and its mask bit are both 1. It returns to 1 once each such bit is cleared or masked.
- R11: `sys_evt[i]` sampled high sets status bit i, for i = 0..4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_mode | input | 1 | 1 = bridge mode, 0 = configuration mode |
| acc_start | input | 1 | Pulse that marks the start of a local bus access |
| lb_ready | input | 1 | Local bus ready handshake |
| lb_irq | input | 1 | Local interrupt input, active high |
| sys_evt | input | 5 | Event pulses for status bits 0–4 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = status register, 1 = mask register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| host_irq_n | output | 1 | Active-low level interrupt to the host |

## Verification
The bench aims at the edges of the ready window. It places ready at the first, fifth and ninth periods, lets a tenth period pass with no ready, and restarts an access partway through the window. A watchdog that is off by one would flag the access that ready reached on the ninth period, or would flag the timeout a cycle early. The bench reads the status register in the same cycle that the timeout and the system events fire, and a design that let the clear win would lose those bits. The bench holds the local interrupt high across a clear and also switches to configuration mode. A level-triggered detector would set bit 15 again at once, and a design that ignored the mode would raise the host interrupt in configuration mode.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
    localparam int REG_W       = 16;
    localparam int NUM_SYS     = 5;
    localparam int BIT_BUS_ERR = 14;
    localparam int BIT_LOC_IRQ = 15;
    localparam logic [REG_W-1:0] IMPL_BITS = 16'hC01F;

    typedef enum logic [0:0] {
        WD_IDLE  = 1'b0,
        WD_COUNT = 1'b1
    } wd_state_e;

    typedef enum logic [0:0] {
        IRQ_ARMED = 1'b0,
        IRQ_HELD  = 1'b1
    } irq_state_e;

    typedef enum logic [0:0] {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/lbs_ready_watchdog.sv
module lbs_ready_watchdog
    import lbs_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ready_i,
    output logic timeout_o
);
    localparam int CNT_W = $clog2(TIMEOUT_CLKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CLKS);

    wd_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= WD_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            WD_IDLE: begin
                cnt_d = '0;
                if (start_i) begin
                    st_d  = WD_COUNT;
                    cnt_d = CNT_W'(1);
                end
            end
            WD_COUNT: begin
                if (start_i) begin
                    cnt_d = CNT_W'(1);
                end else if (ready_i) begin
                    st_d  = WD_IDLE;
                    cnt_d = '0;
                end else if (cnt_q == LIMIT) begin
                    st_d  = WD_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                st_d  = WD_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        timeout_o = 1'b0;
        unique case (st_q)
            WD_IDLE:  timeout_o = 1'b0;
            WD_COUNT: timeout_o = !start_i && !ready_i && (cnt_q == LIMIT);
            default:  timeout_o = 1'b0;
        endcase
    end

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT); // R4

    AST_READY_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_COUNT && ready_i && !start_i) |=> (st_q == WD_IDLE)); // R3

    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q == WD_COUNT && cnt_q == CNT_W'(1))); // R5
endmodule

// File: rtl/lbs_irq_detect.sv
module lbs_irq_detect
    import lbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    output logic event_o
);
    irq_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IRQ_ARMED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_ARMED: if (irq_i)  st_d = IRQ_HELD;
            IRQ_HELD:  if (!irq_i) st_d = IRQ_ARMED;
            default:   st_d = IRQ_ARMED;
        endcase
    end

    always_comb begin
        event_o = 1'b0;
        unique case (st_q)
            IRQ_ARMED: event_o = irq_i;
            IRQ_HELD:  event_o = 1'b0;
            default:   event_o = 1'b0;
        endcase
    end

    AST_ONE_EVENT_PER_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o); // R6
endmodule

// File: rtl/lbs_status_regs.sv
module lbs_status_regs
    import lbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bridge_mode,
    input  logic [REG_W-1:0] set_i,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             host_irq_n
);
    localparam logic [REG_W-1:0] LB_BITS =
        (REG_W'(1) << BIT_BUS_ERR) | (REG_W'(1) << BIT_LOC_IRQ);

    logic [REG_W-1:0] stat_q, mask_q, rdata_q;
    logic             rd_stat, wr_mask;

    assign rd_stat = reg_rd && (reg_sel_e'(reg_addr) == SEL_STATUS);
    assign wr_mask = reg_wr && (reg_sel_e'(reg_addr) == SEL_MASK);

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL_BITS[i]) begin : g_impl
            logic set_ok;
            if (LB_BITS[i]) begin : g_lb
                assign set_ok = set_i[i] && bridge_mode;
            end else begin : g_sys
                assign set_ok = set_i[i];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                         stat_q[i] <= 1'b0;
                else if (LB_BITS[i] && !bridge_mode) stat_q[i] <= 1'b0;
                else if (set_ok)                    stat_q[i] <= 1'b1;
                else if (rd_stat)                   stat_q[i] <= 1'b0;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       mask_q[i] <= 1'b0;
                else if (wr_mask) mask_q[i] <= reg_wdata[i];
            end
            if (!LB_BITS[i]) begin : g_evt_chk
                AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                    set_i[i] |=> stat_q[i]); // R8
            end
        end else begin : g_none
            assign stat_q[i] = 1'b0;
            assign mask_q[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            unique case (reg_sel_e'(reg_addr))
                SEL_STATUS: rdata_q <= stat_q;
                SEL_MASK:   rdata_q <= mask_q;
                default:    rdata_q <= '0;
            endcase
        end
    end

    assign reg_rdata  = rdata_q;
    assign host_irq_n = ~|(stat_q & mask_q);

    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_mode |=> (stat_q[BIT_LOC_IRQ] == 1'b0 && stat_q[BIT_BUS_ERR] == 1'b0)); // R9

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_irq_n && !reg_rd && !reg_wr && bridge_mode) |=> !host_irq_n); // R10

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && set_i == '0 && !reg_wr) |=> (stat_q == '0)); // R7
endmodule

// File: rtl/lbs_monitor.sv
module lbs_monitor
    import lbs_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bridge_mode,
    input  logic               acc_start,
    input  logic               lb_ready,
    input  logic               lb_irq,
    input  logic [NUM_SYS-1:0] sys_evt,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic               reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               host_irq_n
);
    logic             timeout_evt, irq_evt;
    logic [REG_W-1:0] set_vec;

    lbs_ready_watchdog #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (acc_start),
        .ready_i   (lb_ready),
        .timeout_o (timeout_evt)
    );

    lbs_irq_detect u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_i   (lb_irq),
        .event_o (irq_evt)
    );

    always_comb begin
        set_vec              = '0;
        set_vec[NUM_SYS-1:0] = sys_evt;
        set_vec[BIT_BUS_ERR] = timeout_evt;
        set_vec[BIT_LOC_IRQ] = irq_evt;
    end

    lbs_status_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bridge_mode (bridge_mode),
        .set_i       (set_vec),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .host_irq_n  (host_irq_n)
    );
endmodule

// File: tb/tb_lbs_monitor.sv
module tb_lbs_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bridge_mode = 1'b1;
    logic        acc_start = 1'b0;
    logic        lb_ready = 1'b0;
    logic        lb_irq = 1'b0;
    logic [4:0]  sys_evt = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        host_irq_n;

    int checks = 0;
    int errs   = 0;
    logic [15:0] d;

    always #2.5 clk = ~clk;

    lbs_monitor dut (
        .clk(clk), .rst_n(rst_n), .bridge_mode(bridge_mode),
        .acc_start(acc_start), .lb_ready(lb_ready), .lb_irq(lb_irq),
        .sys_evt(sys_evt), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .host_irq_n(host_irq_n)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic a, output logic [15:0] v);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic wr_mask(input logic [15:0] v);
        reg_addr = 1'b1; reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_start();
        acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rdata", reg_rdata, 16'h0);
        chk("R1 irq_n", {15'd0, host_irq_n}, 16'h1);
        rd(1'b0, d); chk("R1 status", d, 16'h0);
        rd(1'b1, d); chk("R1 mask", d, 16'h0);
    endtask

    task automatic t_mask();
        wr_mask(16'hFFFF);
        rd(1'b1, d); chk("R2 unused bits", d, 16'hC01F);
        wr_mask(16'h4002);
        rd(1'b1, d); chk("R2 mask value", d, 16'h4002);
        wr_mask(16'h0000);
    endtask

    task automatic t_ready_at(input int k);
        pulse_start();
        idle(k - 1);
        lb_ready = 1'b1;
        @(negedge clk);
        lb_ready = 1'b0;
        idle(12);
        rd(1'b0, d); chk($sformatf("R3 ready at period %0d", k), d, 16'h0);
    endtask

    task automatic t_timeout();
        wr_mask(16'h4000);
        pulse_start();
        idle(8);
        chk("R10 irq idle", {15'd0, host_irq_n}, 16'h1);
        rd(1'b0, d); chk("R4 not early", d, 16'h0);
        chk("R10 irq low", {15'd0, host_irq_n}, 16'h0);
        lb_ready = 1'b1;
        @(negedge clk);
        lb_ready = 1'b0;
        rd(1'b0, d); chk("R4 R8 timeout kept", d, 16'h4000);
        chk("R7 R10 irq released", {15'd0, host_irq_n}, 16'h1);
        rd(1'b0, d); chk("R4 late ready ignored", d, 16'h0);
        wr_mask(16'h0000);
    endtask

    task automatic t_restart();
        pulse_start();
        idle(4);
        pulse_start();
        idle(8);
        rd(1'b0, d); chk("R5 no timeout in old window", d, 16'h0);
        rd(1'b0, d); chk("R5 timeout after restart", d, 16'h4000);
    endtask

    task automatic t_local_irq();
        lb_irq = 1'b1;
        idle(2);
        rd(1'b0, d); chk("R6 irq detected", d, 16'h8000);
        idle(3);
        rd(1'b0, d); chk("R6 held irq not rearmed", d, 16'h0);
        lb_irq = 1'b0;
        idle(2);
        lb_irq = 1'b1;
        idle(1);
        lb_irq = 1'b0;
        rd(1'b0, d); chk("R6 fresh assert", d, 16'h8000);
    endtask

    task automatic t_sys_events();
        for (int i = 0; i < 5; i++) begin
            sys_evt = 5'(1 << i);
            @(negedge clk);
        end
        sys_evt = '0;
        rd(1'b0, d); chk("R11 all system bits", d, 16'h001F);
        rd(1'b0, d); chk("R7 cleared", d, 16'h0);
        sys_evt = 5'b00100; reg_addr = 1'b0; reg_rd = 1'b1;
        @(negedge clk);
        sys_evt = '0; reg_rd = 1'b0;
        chk("R8 read shows old", reg_rdata, 16'h0);
        rd(1'b0, d); chk("R8 event survived read", d, 16'h0004);
    endtask

    task automatic t_irq_mask();
        sys_evt = 5'b00010;
        @(negedge clk);
        sys_evt = '0;
        chk("R10 masked no irq", {15'd0, host_irq_n}, 16'h1);
        wr_mask(16'h0002);
        chk("R10 unmask irq", {15'd0, host_irq_n}, 16'h0);
        wr_mask(16'h0001);
        chk("R10 remask irq", {15'd0, host_irq_n}, 16'h1);
        rd(1'b0, d); chk("R11 bit1", d, 16'h0002);
        wr_mask(16'h0000);
    endtask

    task automatic t_config_mode();
        wr_mask(16'hC000);
        lb_irq = 1'b1;
        idle(1);
        chk("R10 bridge irq", {15'd0, host_irq_n}, 16'h0);
        bridge_mode = 1'b0;
        idle(1);
        chk("R9 cleared on cfg", {15'd0, host_irq_n}, 16'h1);
        lb_irq = 1'b0;
        idle(1);
        lb_irq = 1'b1;
        pulse_start();
        idle(12);
        chk("R9 cfg irq_n", {15'd0, host_irq_n}, 16'h1);
        rd(1'b0, d); chk("R9 cfg status", d, 16'h0);
        lb_irq = 1'b0;
        bridge_mode = 1'b1;
        wr_mask(16'h0000);
        idle(2);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_mask();
        t_ready_at(1);
        t_ready_at(5);
        t_ready_at(9);
        t_timeout();
        t_restart();
        t_local_irq();
        t_sys_events();
        t_irq_mask();
        t_config_mode();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule